// File: doc/BRIEF.md
# Square-Wave Clock Timer Channel

This block is one 8-bit auto-reload timer channel that can act as a programmable clock generator. A prescaler divides the system clock and yields a single-cycle count tick every (divide value + 1) clocks. Each tick advances the counter. When the counter passes its all-ones value, the counter reloads from a reload register, an overflow flag is raised, and, if clock-output mode is on, the channel's output pin changes level. The result is a 50% duty square wave. Each half-period lasts (256 − reload) × (divide + 1) system clocks, so the output frequency is the system clock divided by 2 × (256 − reload) × (divide + 1).

Software drives the channel through simple write strobes. One strobe loads three control bits together: run, gate enable and clock-output enable. Other strobes load the reload value and the prescaler divide value. When the gate is enabled, counting and toggling stop while an external gate input is low, so an outside signal can pause the clock. The overflow flag keeps working in clock-output mode, and an interrupt-acknowledge pulse clears it.

Top module: `sqclk_timer`

## Requirements
- R1: After reset all control bits, the reload value and the divide value are zero, the counter reads 0, the overflow flag is 0, the output pin is low and its drive enable is low.
- R2: While run is 1, the counter advances once every (divide + 1) system clocks. The first advance comes divide + 1 clocks after run takes effect. The prescaler restarts from zero whenever run is 0.
- R3: On a tick, the counter increments by one. On a tick at value 255, it loads the reload register instead, and this counts as an overflow.
- R4: Every overflow sets the overflow flag, and this also holds while clock-output mode is on.
- R5: An interrupt-acknowledge pulse clears the flag on the next edge. If an overflow falls in the same cycle as the acknowledge, the flag stays set.
- R6: With clock-output enable at 1, the pin drive enable is 1 and the pin inverts on every overflow. Pin changes are spaced (256 − reload) × (divide + 1) clocks apart.
- R7: With run at 0, the counter holds its value and no overflow occurs.
- R8: With gate enable at 1, the counter advances only while the gate input is 1, and it holds its value while the gate input is 0.
- R9: Clearing clock-output enable deasserts the pin drive enable and freezes the pin at its current level, even while overflows continue.
- R10: With reload 255, every tick is an overflow. With divide 0, the pin then changes on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctlWe | input | 1 | Write strobe for the three control bits |
| ctlRun | input | 1 | Run bit value to write |
| ctlGate | input | 1 | Gate-enable bit value to write |
| ctlClkOut | input | 1 | Clock-output-enable bit value to write |
| reloadWe | input | 1 | Write strobe for the reload register |
| reloadVal | input | 8 | Reload value |
| prescWe | input | 1 | Write strobe for the prescaler divide value |
| prescVal | input | 4 | Divide value; ticks come every prescVal+1 clocks |
| gateIn | input | 1 | External gate input |
| intAck | input | 1 | Interrupt-acknowledge pulse, clears the flag |
| cntOut | output | 8 | Current counter value |
| ovfFlag | output | 1 | Overflow flag |
| pinOut | output | 1 | Clock output pin level |
| pinOe | output | 1 | Pin drive enable |

## Verification
An overflow and an interrupt acknowledge can fall in the same cycle: one tries to set the flag while the other tries to clear it. To provoke this, the bench uses reload 255 and divide 3, which gives an overflow every fourth clock. It locks onto the phase by watching a pin change, clears the flag with an acknowledge placed between overflows, and then puts a second acknowledge exactly on the next overflow cycle. The bench expects the flag to drop after the first acknowledge. After the colliding acknowledge, it expects the flag to stay set while the pin toggles.

// File: rtl/sqclk_timer_pkg.sv
package sqclk_timer_pkg;
  // Strobes from the control side to the counting datapath
  typedef struct packed {
    logic tick;      // one-cycle count enable
    logic clkOutEn;  // clock-output mode active
  } tmrStrobe_t;
endpackage

// File: rtl/sqclk_timer_ctrl.sv
module sqclk_timer_ctrl
  import sqclk_timer_pkg::*;
#(
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWe,
  input  logic          ctlRun,
  input  logic          ctlGate,
  input  logic          ctlClkOut,
  input  logic          prescWe,
  input  logic [PW-1:0] prescVal,
  input  logic          gateIn,
  output tmrStrobe_t    strobe
);
  logic          runQ, gateQ, clkOutQ;
  logic [PW-1:0] prescQ;
  logic [PW-1:0] preCnt;
  logic          countEn;
  logic          tick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ    <= 1'b0;
      gateQ   <= 1'b0;
      clkOutQ <= 1'b0;
      prescQ  <= '0;
    end else begin
      if (ctlWe) begin
        runQ    <= ctlRun;
        gateQ   <= ctlGate;
        clkOutQ <= ctlClkOut;
      end
      if (prescWe) prescQ <= prescVal;
    end
  end

  // Counting allowed when running and, if gated, the gate input is high
  assign countEn = runQ && (!gateQ || gateIn);
  assign tick    = countEn && (preCnt == prescQ);

  always_ff @(posedge clk) begin
    if (!rstN || !runQ) begin
      preCnt <= '0;
    end else if (countEn) begin
      preCnt <= tick ? '0 : preCnt + 1'b1;
    end
  end

  assign strobe.tick     = tick;
  assign strobe.clkOutEn = clkOutQ;

  // R2: prescaler restarts while stopped
  p_presc_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |=> (preCnt == '0));

  // R8: a low gate input freezes the prescaler when gating is on
  p_gate_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && gateQ && !gateIn) |=> $stable(preCnt));

endmodule

// File: rtl/sqclk_timer_dp.sv
module sqclk_timer_dp
  import sqclk_timer_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  tmrStrobe_t   strobe,
  input  logic         reloadWe,
  input  logic [W-1:0] reloadVal,
  input  logic         intAck,
  output logic [W-1:0] cntOut,
  output logic         ovfFlag,
  output logic         pinOut,
  output logic         pinOe
);
  localparam logic [W-1:0] CntMax = '1;

  logic [W-1:0] cnt;
  logic [W-1:0] reloadQ;
  logic         flagQ;
  logic         pinQ;
  logic         ovf;

  assign ovf = strobe.tick && (cnt == CntMax);

  always_ff @(posedge clk) begin
    if (!rstN) reloadQ <= '0;
    else if (reloadWe) reloadQ <= reloadVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) cnt <= '0;
    else if (ovf) cnt <= reloadQ;
    else if (strobe.tick) cnt <= cnt + 1'b1;
  end

  // Overflow wins over acknowledge in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) flagQ <= 1'b0;
    else if (ovf) flagQ <= 1'b1;
    else if (intAck) flagQ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) pinQ <= 1'b0;
    else if (ovf && strobe.clkOutEn) pinQ <= ~pinQ;
  end

  assign cntOut  = cnt;
  assign ovfFlag = flagQ;
  assign pinOut  = pinQ;
  assign pinOe   = strobe.clkOutEn;

  // R3: overflow loads the reload value
  p_reload_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && cnt == CntMax) |=> (cnt == $past(reloadQ)));

  // R7: no tick, no change
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.tick |=> $stable(cnt));

  // R4: overflow raises the flag
  p_flag_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && cnt == CntMax) |=> flagQ);

  // R5: acknowledge alone clears the flag
  p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !(strobe.tick && cnt == CntMax)) |=> !flagQ);

  // R6: pin inverts on overflow in clock-output mode
  p_pin_toggle_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.tick && cnt == CntMax && strobe.clkOutEn) |=> (pinQ != $past(pinQ)));

  // R9: pin frozen outside clock-output mode
  p_pin_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clkOutEn |=> $stable(pinQ));

endmodule

// File: rtl/sqclk_timer.sv
module sqclk_timer
  import sqclk_timer_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          ctlWe,
  input  logic          ctlRun,
  input  logic          ctlGate,
  input  logic          ctlClkOut,
  input  logic          reloadWe,
  input  logic [W-1:0]  reloadVal,
  input  logic          prescWe,
  input  logic [PW-1:0] prescVal,
  input  logic          gateIn,
  input  logic          intAck,
  output logic [W-1:0]  cntOut,
  output logic          ovfFlag,
  output logic          pinOut,
  output logic          pinOe
);
  tmrStrobe_t strobe;

  sqclk_timer_ctrl #(.PW(PW)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .ctlWe(ctlWe), .ctlRun(ctlRun), .ctlGate(ctlGate), .ctlClkOut(ctlClkOut),
    .prescWe(prescWe), .prescVal(prescVal),
    .gateIn(gateIn),
    .strobe(strobe)
  );

  sqclk_timer_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(rstN),
    .strobe(strobe),
    .reloadWe(reloadWe), .reloadVal(reloadVal),
    .intAck(intAck),
    .cntOut(cntOut), .ovfFlag(ovfFlag),
    .pinOut(pinOut), .pinOe(pinOe)
  );

  // R1: quiet outputs right after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!pinOut && !pinOe && !ovfFlag && cntOut == '0));

endmodule

// File: tb/sqclk_timer_tb_top.sv
module sqclk_timer_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctlWe = 1'b0, ctlRun = 1'b0, ctlGate = 1'b0, ctlClkOut = 1'b0;
  logic       reloadWe = 1'b0;
  logic [7:0] reloadVal = '0;
  logic       prescWe = 1'b0;
  logic [3:0] prescVal = '0;
  logic       gateIn = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] cntOut;
  logic       ovfFlag, pinOut, pinOe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sqclk_timer dut_i (
    .clk(clk), .rstN(rstN),
    .ctlWe(ctlWe), .ctlRun(ctlRun), .ctlGate(ctlGate), .ctlClkOut(ctlClkOut),
    .reloadWe(reloadWe), .reloadVal(reloadVal),
    .prescWe(prescWe), .prescVal(prescVal),
    .gateIn(gateIn), .intAck(intAck),
    .cntOut(cntOut), .ovfFlag(ovfFlag), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic applyReset();
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeCtl(bit run, bit gate, bit clkOut);
    ctlWe = 1'b1; ctlRun = run; ctlGate = gate; ctlClkOut = clkOut;
    @(posedge clk); @(negedge clk);
    ctlWe = 1'b0;
  endtask

  task automatic writeReload(int v);
    reloadWe = 1'b1; reloadVal = 8'(v);
    @(posedge clk); @(negedge clk);
    reloadWe = 1'b0;
  endtask

  task automatic writePresc(int v);
    prescWe = 1'b1; prescVal = 4'(v);
    @(posedge clk); @(negedge clk);
    prescWe = 1'b0;
  endtask

  // Falling edges until the pin changes level; -1 if none within limit
  task automatic waitPinChange(output int n);
    logic last = pinOut;
    n = -1;
    for (int i = 1; i <= 3000; i++) begin
      @(negedge clk);
      if (pinOut != last) begin n = i; break; end
    end
  endtask

  task automatic testReset();
    applyReset();
    check("R1 pinOut", int'(pinOut), 0);
    check("R1 pinOe", int'(pinOe), 0);
    check("R1 ovfFlag", int'(ovfFlag), 0);
    check("R1 cntOut", int'(cntOut), 0);
    // control bits zero: nothing counts without a write
    repeat (10) @(negedge clk);
    check("R1 idle count", int'(cntOut), 0);
  endtask

  task automatic testPrescale();
    applyReset();
    writePresc(2);
    writeCtl(1, 0, 0);
    repeat (2) @(negedge clk);
    check("R2 before first tick", int'(cntOut), 0);
    repeat (2) @(negedge clk);
    check("R2 R3 first tick", int'(cntOut), 1);
    writeCtl(0, 0, 0);
    repeat (5) @(negedge clk);
    check("R7 held when stopped", int'(cntOut), 1);
    writeCtl(1, 0, 0);
    repeat (2) @(negedge clk);
    check("R2 prescaler restarted", int'(cntOut), 1);
    @(negedge clk);
    check("R2 tick after restart", int'(cntOut), 2);
  endtask

  task automatic testToggle();
    int n;
    applyReset();
    writeReload(250);
    writePresc(1);
    writeCtl(1, 0, 1);
    check("R6 pinOe on", int'(pinOe), 1);
    waitPinChange(n);
    check("R6 first change seen", int'(n > 0), 1);
    check("R4 flag in clock mode", int'(ovfFlag), 1);
    check("R3 reloaded", int'(cntOut), 250);
    waitPinChange(n);
    check("R6 half period", n, 12);
    waitPinChange(n);
    check("R6 half period again", n, 12);
  endtask

  task automatic testFast();
    int n;
    applyReset();
    writeReload(255);
    writeCtl(1, 0, 1);
    waitPinChange(n);
    waitPinChange(n);
    check("R10 toggle every clock", n, 1);
    writePresc(2);
    waitPinChange(n);
    waitPinChange(n);
    check("R10 toggle every tick", n, 3);
  endtask

  task automatic testAck();
    int n;
    applyReset();
    writeReload(255);
    writePresc(3);
    writeCtl(1, 0, 1);
    waitPinChange(n);
    waitPinChange(n);
    check("R10 period 4", n, 4);
    check("R4 flag set", int'(ovfFlag), 1);
    // overflow edge just passed; next one is 4 edges later
    intAck = 1'b1;
    @(posedge clk); @(negedge clk);
    intAck = 1'b0;
    check("R5 ack clears", int'(ovfFlag), 0);
    begin
      logic pinBefore = pinOut;
      repeat (2) @(negedge clk);
      intAck = 1'b1;
      @(posedge clk); @(negedge clk);
      intAck = 1'b0;
      check("R5 overflow beats ack", int'(ovfFlag), 1);
      check("R6 toggled on collision", int'(pinOut != pinBefore), 1);
    end
  endtask

  task automatic testGate();
    applyReset();
    gateIn = 1'b0;
    writeCtl(1, 1, 0);
    repeat (20) @(negedge clk);
    check("R8 gate low holds", int'(cntOut), 0);
    gateIn = 1'b1;
    repeat (10) @(negedge clk);
    check("R8 gate high counts", int'(cntOut), 10);
    gateIn = 1'b0;
    repeat (10) @(negedge clk);
    check("R8 gate low again", int'(cntOut), 10);
  endtask

  task automatic testFreeze();
    logic frozen;
    applyReset();
    writeReload(255);
    writeCtl(1, 0, 1);
    repeat (300) @(negedge clk);
    writeCtl(1, 0, 0);
    frozen = pinOut;
    check("R9 pinOe off", int'(pinOe), 0);
    intAck = 1'b1;
    @(posedge clk); @(negedge clk);
    intAck = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 pin frozen", int'(pinOut), int'(frozen));
    check("R4 flag still works", int'(ovfFlag), 1);
  endtask

  initial begin
    testReset();
    testPrescale();
    testToggle();
    testFast();
    testAck();
    testGate();
    testFreeze();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule